// File: doc/BRIEF.md
# Level Detector Input Source Selector and Formatter

This block feeds the level-detector path of one receive channel. Each cycle it picks one of several parallel sample buses, or a test register written by a control processor, as the channel's data source. It can treat the incoming samples as offset binary and turn them into two's complement. It also produces a data-valid flag and a 3-bit normalized shift code.

The test register path has two valid modes. In pulse mode, each processor write yields a valid flag for exactly one output cycle, which lets software inject test samples one at a time. In level mode, a separate active-low enable bit drives the valid flag as a steady level. With the enable high and a zero written, the channel input can be parked at a constant or silenced. The shift code is the incoming floating-point exponent plus the ones-complement of a programmed saturation level, taken modulo 8, so that inputs with different maximum exponents line up at full scale.

All three outputs are registered and appear one clock after the inputs that produce them.

Top module: `lsf_top`

## Requirements
- R1: While `rst_n` is low, `out_sample`, `out_valid` and `out_shift` are zero, and the test register is cleared to zero.
- R2: Source codes 0 to NUM_BUS-1 (000 = bus A, 001 = bus B, 010 = bus C, 011 = bus D with the defaults) select bits [16*i+15:16*i] of `bus_in`, with `out_valid` high.
- R3: Source code NUM_BUS (100 with the defaults) selects the test register as the data source.
- R4: Source codes above NUM_BUS (101, 110 and 111) give `out_sample` of zero and `out_valid` low, whatever the format bit is.
- R5: `cfg_offset_bin` = 0 passes the selected sample unchanged (two's complement). `cfg_offset_bin` = 1 inverts its most significant bit (offset binary to two's complement). This applies to both the bus sources and the test source.
- R6: With code 100 and `cfg_en_mode` = 0, `out_valid` is high for exactly one cycle per cycle in which `tst_wr_en` is high, and `out_sample` then carries that written word. In all other cycles `out_valid` is low.
- R7: With code 100 and `cfg_en_mode` = 1, `out_valid` equals the inverse of `cfg_en_n` (0 = enabled), whether or not a write happens.
- R8: A cycle with `tst_wr_en` high stores `tst_wr_data` in the test register, whatever source is selected. The register keeps that value until the next write. The written word is also forwarded to the output in the write cycle itself.
- R9: `out_shift` = (`exp_in` + ~`cfg_sat`) mod 8 for every source. A saturation level of 000, used for fixed-point inputs, gives `exp_in` - 1 mod 8.
- R10: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | NUM_BUS*DATA_W | Parallel sample buses, bus i in bits [DATA_W*i +: DATA_W] |
| tst_wr_en | input | 1 | Processor write strobe for the test register |
| tst_wr_data | input | DATA_W | Processor write data for the test register |
| cfg_src | input | 3 | Source code |
| cfg_offset_bin | input | 1 | 1 = samples are offset binary |
| cfg_en_mode | input | 1 | 0 = pulse per write, 1 = level from cfg_en_n |
| cfg_en_n | input | 1 | Active-low test input enable, used in level mode |
| cfg_sat | input | EXP_W | Saturation level for exponent normalization |
| exp_in | input | EXP_W | Incoming floating-point exponent |
| out_sample | output | DATA_W | Formatted sample |
| out_valid | output | 1 | Sample valid |
| out_shift | output | EXP_W | Normalized shift code |

## Verification
The bound checker watches the following on every clock:
- the one-cycle relation between the ports for the shift code;
- the zero, invalid output for the unused source codes;
- the valid flag for bus sources, for pulse mode (idle and write cycles) and for level mode;
- format handling of bus A;
- quiet outputs during reset.

Some behaviours depend on state held across many cycles, and only the bench scenarios can show them:
- the test register keeping a word written while a bus was selected;
- the reset value of that register;
- the data that pulse and level mode present after a gap in writes.

The bench model also sweeps all 64 exponent and saturation pairs.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    // Test-register valid mode
    typedef enum logic {
        EN_PULSE = 1'b0,
        EN_LEVEL = 1'b1
    } lsf_en_mode_e;

    // Incoming sample format
    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } lsf_fmt_e;

    // Offset binary to two's complement: flip the sign bit
    function automatic logic [63:0] lsf_msb_mask(input int unsigned width, input logic on);
        logic [63:0] m;
        m = '0;
        if (on) m[width-1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/lsf_test_reg.sv
module lsf_test_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              en_mode,
    input  logic              en_n,
    output logic [DATA_W-1:0] tst_data,
    output logic              tst_valid
);
    import lsf_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } treg_t;

    treg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.word = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Write-through so a pulse carries the word being written
    always_comb begin
        tst_data = wr_en ? wr_data : st_q.word;
        unique case (lsf_en_mode_e'(en_mode))
            EN_PULSE: tst_valid = wr_en;
            EN_LEVEL: tst_valid = ~en_n;
            default:  tst_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsf_src_mux.sv
module lsf_src_mux #(
    parameter int DATA_W  = 16,
    parameter int NUM_BUS = 4,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_BUS*DATA_W-1:0] bus_in,
    input  logic [SEL_W-1:0]          sel,
    input  logic [DATA_W-1:0]         tst_data,
    input  logic                      tst_valid,
    input  logic                      offset_bin,
    output logic [DATA_W-1:0]         data,
    output logic                      valid
);
    import lsf_pkg::*;

    localparam logic [SEL_W-1:0] TEST_CODE = SEL_W'(NUM_BUS);

    logic [DATA_W-1:0] bus_arr [NUM_BUS];
    logic [DATA_W-1:0] raw;
    logic              hit;
    logic [63:0]       mask;

    for (genvar gi = 0; gi < NUM_BUS; gi++) begin : g_unpack
        assign bus_arr[gi] = bus_in[gi*DATA_W +: DATA_W];
    end

    always_comb begin
        raw   = '0;
        valid = 1'b0;
        hit   = 1'b0;
        for (int i = 0; i < NUM_BUS; i++) begin
            if (sel == SEL_W'(i)) begin
                raw   = bus_arr[i];
                valid = 1'b1;
                hit   = 1'b1;
            end
        end
        if (sel == TEST_CODE) begin
            raw   = tst_data;
            valid = tst_valid;
            hit   = 1'b1;
        end
        mask = lsf_msb_mask(DATA_W, hit && (lsf_fmt_e'(offset_bin) == FMT_OFFSET));
        data = raw ^ mask[DATA_W-1:0];
    end

endmodule

// File: rtl/lsf_shift.sv
module lsf_shift #(
    parameter int EXP_W = 3
) (
    input  logic [EXP_W-1:0] exponent,
    input  logic [EXP_W-1:0] sat_level,
    output logic [EXP_W-1:0] shift_code
);
    always_comb begin
        shift_code = exponent + ~sat_level;   // wraps modulo 2**EXP_W
    end
endmodule

// File: rtl/lsf_top.sv
module lsf_top #(
    parameter int DATA_W  = 16,
    parameter int NUM_BUS = 4,
    parameter int EXP_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BUS*DATA_W-1:0] bus_in,
    input  logic                      tst_wr_en,
    input  logic [DATA_W-1:0]         tst_wr_data,
    input  logic [2:0]                cfg_src,
    input  logic                      cfg_offset_bin,
    input  logic                      cfg_en_mode,
    input  logic                      cfg_en_n,
    input  logic [EXP_W-1:0]          cfg_sat,
    input  logic [EXP_W-1:0]          exp_in,
    output logic [DATA_W-1:0]         out_sample,
    output logic                      out_valid,
    output logic [EXP_W-1:0]          out_shift
);
    localparam int SEL_W = 3;

    typedef struct packed {
        logic [DATA_W-1:0] sample;
        logic              valid;
        logic [EXP_W-1:0]  shift;
    } out_t;

    out_t o_d, o_q;

    logic [DATA_W-1:0] tst_data;
    logic              tst_valid;
    logic [DATA_W-1:0] mux_data;
    logic              mux_valid;
    logic [EXP_W-1:0]  shift_c;

    lsf_test_reg #(.DATA_W(DATA_W)) u_treg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tst_wr_en),
        .wr_data   (tst_wr_data),
        .en_mode   (cfg_en_mode),
        .en_n      (cfg_en_n),
        .tst_data  (tst_data),
        .tst_valid (tst_valid)
    );

    lsf_src_mux #(.DATA_W(DATA_W), .NUM_BUS(NUM_BUS), .SEL_W(SEL_W)) u_mux (
        .bus_in     (bus_in),
        .sel        (cfg_src),
        .tst_data   (tst_data),
        .tst_valid  (tst_valid),
        .offset_bin (cfg_offset_bin),
        .data       (mux_data),
        .valid      (mux_valid)
    );

    lsf_shift #(.EXP_W(EXP_W)) u_shift (
        .exponent   (exp_in),
        .sat_level  (cfg_sat),
        .shift_code (shift_c)
    );

    always_comb begin
        o_d        = o_q;
        o_d.sample = mux_data;
        o_d.valid  = mux_valid;
        o_d.shift  = shift_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_sample = o_q.sample;
    assign out_valid  = o_q.valid;
    assign out_shift  = o_q.shift;

endmodule

// File: rtl/lsf_chk.sv
module lsf_chk #(
    parameter int DATA_W  = 16,
    parameter int NUM_BUS = 4,
    parameter int EXP_W   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_BUS*DATA_W-1:0] bus_in,
    input logic                      tst_wr_en,
    input logic [2:0]                cfg_src,
    input logic                      cfg_offset_bin,
    input logic                      cfg_en_mode,
    input logic                      cfg_en_n,
    input logic [EXP_W-1:0]          cfg_sat,
    input logic [EXP_W-1:0]          exp_in,
    input logic [DATA_W-1:0]         out_sample,
    input logic                      out_valid,
    input logic [EXP_W-1:0]          out_shift
);
    localparam logic [2:0] TEST_CODE = 3'(NUM_BUS);

    // Set once one edge has passed out of reset, so $past sees live inputs
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (out_sample == '0 && !out_valid && out_shift == '0));

    // R4
    bad_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cfg_src) > TEST_CODE |-> (!out_valid && out_sample == '0));

    // R2
    bus_valid_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cfg_src) < TEST_CODE |-> out_valid);

    // R5
    bus_a_format_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cfg_src) == 3'd0 |->
        out_sample == ($past(bus_in[DATA_W-1:0]) ^ {$past(cfg_offset_bin), {(DATA_W-1){1'b0}}}));

    // R6
    pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cfg_src == TEST_CODE && !cfg_en_mode && !tst_wr_en) |-> !out_valid);

    // R6
    pulse_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cfg_src == TEST_CODE && !cfg_en_mode && tst_wr_en) |-> out_valid);

    // R7
    level_valid_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(cfg_src == TEST_CODE && cfg_en_mode) |-> out_valid == !$past(cfg_en_n));

    // R9
    shift_norm_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        1'b1 |-> out_shift == EXP_W'($past(exp_in) - $past(cfg_sat) - 1'b1));

endmodule

bind lsf_top lsf_chk #(.DATA_W(DATA_W), .NUM_BUS(NUM_BUS), .EXP_W(EXP_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_in         (bus_in),
    .tst_wr_en      (tst_wr_en),
    .cfg_src        (cfg_src),
    .cfg_offset_bin (cfg_offset_bin),
    .cfg_en_mode    (cfg_en_mode),
    .cfg_en_n       (cfg_en_n),
    .cfg_sat        (cfg_sat),
    .exp_in         (exp_in),
    .out_sample     (out_sample),
    .out_valid      (out_valid),
    .out_shift      (out_shift)
);

// File: tb/lsf_top_tb.sv
`timescale 1ns/1ps
module lsf_top_tb;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int EW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NB*DW-1:0] bus_in = '0;
    logic           tst_wr_en = 1'b0;
    logic [DW-1:0]  tst_wr_data = '0;
    logic [2:0]     cfg_src = '0;
    logic           cfg_offset_bin = 1'b0;
    logic           cfg_en_mode = 1'b0;
    logic           cfg_en_n = 1'b1;
    logic [EW-1:0]  cfg_sat = '0;
    logic [EW-1:0]  exp_in = '0;
    logic [DW-1:0]  out_sample;
    logic           out_valid;
    logic [EW-1:0]  out_shift;

    int checks = 0;
    int errors = 0;
    int ref_treg = 0;   // model of the test register

    always #2 clk = ~clk;   // 250 MHz

    lsf_top #(.DATA_W(DW), .NUM_BUS(NB), .EXP_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .tst_wr_en(tst_wr_en), .tst_wr_data(tst_wr_data),
        .cfg_src(cfg_src), .cfg_offset_bin(cfg_offset_bin),
        .cfg_en_mode(cfg_en_mode), .cfg_en_n(cfg_en_n),
        .cfg_sat(cfg_sat), .exp_in(exp_in),
        .out_sample(out_sample), .out_valid(out_valid), .out_shift(out_shift)
    );

    task automatic compare(string req, int es, int ev, int esh);
        checks++;
        if (int'(out_sample) != es || int'(out_valid) != ev || int'(out_shift) != esh) begin
            errors++;
            $display("FAIL %s: actual sample=%h valid=%0d shift=%0d expected sample=%h valid=%0d shift=%0d",
                     req, out_sample, out_valid, out_shift, es, ev, esh);
        end
    endtask

    // One clock: model expected outputs from the present inputs, then compare after the edge
    task automatic tick(string req);
        int code = int'(cfg_src);
        int d, v, sh;
        if (code < NB) begin
            d = int'(bus_in[code*DW +: DW]);
            v = 1;
        end else if (code == NB) begin
            d = tst_wr_en ? int'(tst_wr_data) : ref_treg;
            v = cfg_en_mode ? int'(!cfg_en_n) : int'(tst_wr_en);
        end else begin
            d = 0;
            v = 0;
        end
        if (code <= NB && cfg_offset_bin) d = d ^ 32'h8000;
        sh = (int'(exp_in) + 7 - int'(cfg_sat)) % 8;
        if (tst_wr_en) ref_treg = int'(tst_wr_data);
        @(posedge clk);
        #1;
        compare(req, d, v, sh);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bus_in = {16'hD4D4, 16'hC3C3, 16'hB2B2, 16'hA1A1};
        cfg_src = 3'd0;
        exp_in = 3'd5;
        cfg_sat = 3'd5;
        tst_wr_en = 1'b1;            // ignored while in reset
        tst_wr_data = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 0, 0, 0);
        tst_wr_en = 1'b0;
        rst_n = 1'b1;

        // R1: test register cleared by reset; R7 level mode enabled
        cfg_src = 3'd4; cfg_en_mode = 1'b1; cfg_en_n = 1'b0;
        tick("R1");

        // R2 / R5 / R10: each bus, both formats
        for (int f = 0; f < 2; f++) begin
            cfg_offset_bin = f[0];
            for (int c = 0; c < NB; c++) begin
                cfg_src = 3'(c);
                tick(f == 0 ? "R2" : "R5");
            end
        end
        bus_in = {16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF};
        for (int c = 0; c < NB; c++) begin
            cfg_src = 3'(c);
            cfg_offset_bin = c[0];
            tick("R5");
        end

        // R4: unused codes, either format
        bus_in = {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0};
        for (int c = 5; c < 8; c++) begin
            cfg_src = 3'(c);
            cfg_offset_bin = c[0];
            tick("R4");
        end

        // R8: write while a bus is selected, then read back through the test source
        cfg_src = 3'd1; cfg_offset_bin = 1'b0;
        tst_wr_en = 1'b1; tst_wr_data = 16'h3C5A;
        tick("R8");
        tst_wr_en = 1'b0;
        tick("R8");
        cfg_src = 3'd4; cfg_en_mode = 1'b1; cfg_en_n = 1'b0;
        tick("R8");
        tick("R3");

        // R6: pulse mode, writes with gaps and back-to-back, both formats
        cfg_en_mode = 1'b0;
        tick("R6");
        tst_wr_en = 1'b1; tst_wr_data = 16'h0101;
        tick("R6");
        tst_wr_en = 1'b0;
        tick("R6");
        tick("R6");
        cfg_offset_bin = 1'b1;
        tst_wr_en = 1'b1; tst_wr_data = 16'h8F00;
        tick("R6");
        tst_wr_data = 16'h0077;
        tick("R6");
        tst_wr_en = 1'b0;
        tick("R6");
        cfg_offset_bin = 1'b0;

        // R7: level mode follows the active-low enable, with and without writes
        cfg_en_mode = 1'b1; cfg_en_n = 1'b1;
        tick("R7");
        tst_wr_en = 1'b1; tst_wr_data = 16'h4242;
        tick("R7");
        tst_wr_en = 1'b0;
        tick("R7");
        cfg_en_n = 1'b0;
        tick("R7");
        tick("R7");
        cfg_en_n = 1'b1;
        tick("R7");

        // R9: every exponent and saturation pair, varying the source
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 8; e++) begin
                cfg_sat = 3'(s);
                exp_in  = 3'(e);
                cfg_src = 3'((s + e) % 8);
                tick("R9");
            end
        end

        // R10: inputs change every cycle, output trails by one
        for (int k = 0; k < 8; k++) begin
            bus_in[DW-1:0] = 16'(k * 16'h1111);
            cfg_src = 3'd0;
            exp_in = 3'(k);
            tick("R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule